// File: doc/BRIEF.md
# Dual-Path Word Queue

This block is a single-clock first-in first-out queue of 32-bit words that can be loaded and emptied from two sides. Software uses a small word-addressed register port with separate read and write strobes; hardware uses a streaming sink (write strobe plus data) and a show-ahead source (the oldest word is always presented, and a read strobe advances it). A configuration word picks, independently, which side feeds the queue and which side drains it, so the same storage can carry data from software to logic, from logic to software, or between two pieces of logic while software watches the fill state.

The register port exposes the configuration word, an empty flag, a full flag, the fill level, a push window, a pop window and a clear command. Register reads return data one clock after the read strobe. The fill level is kept in log2(depth) bits, so a completely full queue reports level zero; the full flag tells the two cases apart.

Top module: `dual_path_fifo`

## Requirements
- R1: After reset the configuration reads 0, the empty flag reads 1, the full flag reads 0 and the level reads 0.
- R2: A value written to address 0 reads back unchanged from address 0; bit 0 selects the feeding side (0 = register push window, 1 = hardware sink) and bit 1 selects the draining side (0 = register pop window, 1 = hardware source).
- R3: A read of address 1 returns 0x00000001 when the queue holds no words and 0x00000000 otherwise.
- R4: A read of address 2 returns 0x00000001 when the queue holds DEPTH words (1024 by default) and 0x00000000 otherwise.
- R5: A read of address 3 returns the number of stored words modulo DEPTH, so a full queue reads 0.
- R6: With bit 0 clear, a register write to address 4 stores the write data; with bit 1 clear, a register read of address 5 returns the oldest word one clock after the strobe and removes it, preserving arrival order.
- R7: With bit 0 set, every clock on which the hardware write strobe is high stores the hardware write data, one word per clock.
- R8: The hardware read-data output shows the oldest stored word without any strobe (0 when the queue is empty); with bit 1 set, a one-clock hardware read strobe removes that word and the next one appears after that edge.
- R9: Strobes on the side not selected by the configuration are ignored: the level and contents do not change, and a deselected register pop returns 0.
- R10: A push while full is dropped and a pop while empty is dropped, with no change to the stored words; a register pop while empty returns 0.
- R11: A register write to address 6 with bit 0 of the data set empties the queue; a write there with bit 0 clear has no effect.
- R12: Reads of addresses 4 and 6 to 15 return 0, and writes to addresses 7 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 4 | Word address of the register access |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Register read data, valid one clock after reg_rd |
| hw_wr | input | 1 | Hardware sink write strobe |
| hw_wdata | input | 32 | Hardware sink data |
| hw_rd | input | 1 | Hardware source advance strobe |
| hw_rdata | output | 32 | Oldest stored word, show-ahead |

## Verification
The assertions watch, on every cycle, that the stored count never passes the depth, that a push into a full queue or a pop from an empty one leaves the pointers where they were, that a clear leaves the queue empty on the next clock, that the flag and undefined-address reads return what the state was at the strobe, and that the configuration only changes on its own write. Data order, the show-ahead timing of the hardware source, the wrap of the level to zero at capacity, the steering of each configuration and the ignoring of deselected strobes need whole sequences of traffic, so only the bench's scenarios with their reference queue can show them.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    RA_CFG   = 4'd0,
    RA_EMPTY = 4'd1,
    RA_FULL  = 4'd2,
    RA_LEVEL = 4'd3,
    RA_PUSH  = 4'd4,
    RA_POP   = 4'd5,
    RA_CLEAR = 4'd6
  } reg_addr_e;

  // Configuration bit positions
  localparam int CFG_SINK_BIT = 0;
  localparam int CFG_SRC_BIT  = 1;

endpackage

// File: rtl/dpf_store.sv
module dpf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  logic              clear,
  output logic [DATA_W-1:0] head_data,
  output logic              empty,
  output logic              full,
  output logic [PTR_W-1:0]  level
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;

  // Named internal events
  logic push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic up, input logic down);
    case ({up, down})
      2'b10:   return c + CNT_W'(1);
      2'b01:   return c - CNT_W'(1);
      default: return c;
    endcase
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign push_ok = push && !full && !clear;
  assign pop_ok  = pop && !empty && !clear;
  assign level   = count[PTR_W-1:0];
  assign head_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= step_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= step_ptr(rd_ptr);
      count <= next_count(count, push_ok, pop_ok);
    end
  end

  p_bounded_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  p_drop_push_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !clear |=> $stable(wr_ptr) && full);

  p_drop_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !push && !clear |=> $stable(rd_ptr) && empty);

  p_clear_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> empty && !full);

  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2
      p_ptr_gap_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        PTR_W'(wr_ptr - rd_ptr) == level);
    end
  endgenerate

endmodule

// File: rtl/dpf_regs.sv
module dpf_regs
  import dpf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              empty,
  input  logic              full,
  input  logic [PTR_W-1:0]  level,
  input  logic [DATA_W-1:0] head_data,
  output logic              sink_hw,
  output logic              src_hw,
  output logic              sw_push,
  output logic              sw_pop,
  output logic              clear_req
);

  logic [DATA_W-1:0] cfg_q;
  logic              cfg_wr;

  function automatic logic [DATA_W-1:0] flag_word(input logic f);
    return {{(DATA_W-1){1'b0}}, f};
  endfunction

  assign sink_hw   = cfg_q[CFG_SINK_BIT];
  assign src_hw    = cfg_q[CFG_SRC_BIT];
  assign cfg_wr    = reg_wr && (reg_addr == RA_CFG);
  assign sw_push   = reg_wr && (reg_addr == RA_PUSH) && !sink_hw;
  assign sw_pop    = reg_rd && (reg_addr == RA_POP) && !src_hw;
  assign clear_req = reg_wr && (reg_addr == RA_CLEAR) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_wr) cfg_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        RA_CFG:   reg_rdata <= cfg_q;
        RA_EMPTY: reg_rdata <= flag_word(empty);
        RA_FULL:  reg_rdata <= flag_word(full);
        RA_LEVEL: reg_rdata <= {{(DATA_W-PTR_W){1'b0}}, level};
        RA_POP:   reg_rdata <= (sw_pop && !empty) ? head_data : '0;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  p_empty_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == RA_EMPTY |=> reg_rdata == flag_word($past(empty)));

  p_full_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == RA_FULL |=> reg_rdata == flag_word($past(full)));

  p_undef_read_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr > RA_CLEAR |=> reg_rdata == '0);

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_q));

  p_pop_empty_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == RA_POP && empty |=> reg_rdata == '0);

endmodule

// File: rtl/dual_path_fifo.sv
module dual_path_fifo
  import dpf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              hw_wr,
  input  logic [DATA_W-1:0] hw_wdata,
  input  logic              hw_rd,
  output logic [DATA_W-1:0] hw_rdata
);

  logic              sink_hw, src_hw;
  logic              sw_push, sw_pop, clear_req;
  logic              push, pop;
  logic [DATA_W-1:0] push_data, head_data;
  logic              empty, full;
  logic [PTR_W-1:0]  level;

  // Side steering from the configuration bits
  assign push      = sink_hw ? hw_wr : sw_push;
  assign push_data = sink_hw ? hw_wdata : reg_wdata;
  assign pop       = src_hw ? hw_rd : sw_pop;
  assign hw_rdata  = empty ? '0 : head_data;

  dpf_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .empty     (empty),
    .full      (full),
    .level     (level),
    .head_data (head_data),
    .sink_hw   (sink_hw),
    .src_hw    (src_hw),
    .sw_push   (sw_push),
    .sw_pop    (sw_pop),
    .clear_req (clear_req)
  );

  dpf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .clear     (clear_req),
    .head_data (head_data),
    .empty     (empty),
    .full      (full),
    .level     (level)
  );

  p_hw_sink_deselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sink_hw && hw_wr && !sw_push && !pop && !clear_req |=> $stable(level) && $stable(empty));

  p_hw_src_deselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !src_hw && hw_rd && !sw_pop && !push && !clear_req |=> $stable(hw_rdata) && $stable(level));

endmodule

// File: tb/dual_path_fifo_bench.sv
module dual_path_fifo_bench;

  localparam int DW    = 32;
  localparam int DEPTH = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic          reg_rd = 1'b0;
  logic [DW-1:0] reg_rdata;
  logic          hw_wr = 1'b0;
  logic [DW-1:0] hw_wdata = '0;
  logic          hw_rd = 1'b0;
  logic [DW-1:0] hw_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  logic [DW-1:0] sb_q[$];
  logic [1:0]    cfg_m = 2'b00;

  always #5 clk = ~clk;

  dual_path_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_dual_path_fifo (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .hw_wr(hw_wr), .hw_wdata(hw_wdata), .hw_rd(hw_rd), .hw_rdata(hw_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [DW-1:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    v = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [DW-1:0] exp, input string req);
    logic [DW-1:0] v;
    reg_read(a, v);
    chk(v == exp, req, v, exp);
  endtask

  task automatic expect_level(input string req);
    expect_reg(4'd3, DW'(sb_q.size() % DEPTH), req);
  endtask

  task automatic set_cfg(input logic [DW-1:0] v);
    reg_write(4'd0, v);
    cfg_m = v[1:0];
  endtask

  // Driver: register push, model records accepted words
  task automatic sw_push(input logic [DW-1:0] d);
    reg_write(4'd4, d);
    if (!cfg_m[0] && sb_q.size() < DEPTH) sb_q.push_back(d);
  endtask

  // Driver: hardware burst, one word per clock
  task automatic hw_burst(input int n, input logic [DW-1:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hw_wr = 1'b1; hw_wdata = base + DW'(i);
      if (cfg_m[0] && sb_q.size() < DEPTH) sb_q.push_back(base + DW'(i));
    end
    @(negedge clk);
    hw_wr = 1'b0;
  endtask

  // Monitor side: register pop compared against scoreboard
  task automatic sw_pop_check(input string req);
    logic [DW-1:0] v, exp;
    reg_read(4'd5, v);
    exp = (!cfg_m[1] && sb_q.size() > 0) ? sb_q.pop_front() : '0;
    chk(v == exp, req, v, exp);
  endtask

  // Monitor side: show-ahead output compared, then advanced
  task automatic hw_pop_check(input string req);
    logic [DW-1:0] exp;
    @(negedge clk);
    exp = (sb_q.size() > 0) ? sb_q[0] : '0;
    chk(hw_rdata == exp, req, hw_rdata, exp);
    hw_rd = 1'b1;
    @(negedge clk);
    hw_rd = 1'b0;
    if (cfg_m[1] && sb_q.size() > 0) void'(sb_q.pop_front());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    expect_reg(4'd0, 32'h0, "R1 cfg");
    expect_reg(4'd1, 32'h1, "R1 empty");
    expect_reg(4'd2, 32'h0, "R1 full");
    expect_reg(4'd3, 32'h0, "R1 level");

    // R2: configuration readback
    set_cfg(32'hDEAD_BEE0);
    expect_reg(4'd0, 32'hDEAD_BEE0, "R2 readback");

    // R6/R3/R5: register push and pop in order
    sw_push(32'h1111_0001);
    sw_push(32'h2222_0002);
    sw_push(32'h3333_0003);
    expect_reg(4'd1, 32'h0, "R3 not empty");
    expect_level("R5 level 3");
    sw_pop_check("R6 pop first");
    sw_pop_check("R6 pop second");
    sw_pop_check("R6 pop third");
    expect_reg(4'd1, 32'h1, "R3 empty after drain");
    // R10: pop while empty
    sw_pop_check("R10 pop empty returns 0");
    expect_level("R10 level after empty pop");

    // R12: undefined addresses
    reg_write(4'd9, 32'hFFFF_FFFF);
    reg_write(4'd15, 32'h0000_0003);
    expect_reg(4'd9, 32'h0, "R12 read addr 9");
    expect_reg(4'd4, 32'h0, "R12 read push window");
    expect_reg(4'd0, 32'hDEAD_BEE0, "R12 cfg untouched");
    expect_level("R12 level untouched");

    // R7/R9: hardware sink, register source
    set_cfg(32'h1);
    sw_push(32'hBAD0_0000);
    expect_level("R9 register push ignored");
    hw_burst(5, 32'hA000_0000);
    expect_level("R7 level after burst");
    sw_pop_check("R7 pop hw word 0");
    sw_pop_check("R7 pop hw word 1");
    // R9: hardware read strobe ignored while register side drains
    @(negedge clk); hw_rd = 1'b1; @(negedge clk); hw_rd = 1'b0;
    expect_level("R9 hw read ignored");

    // R8/R9: hardware source
    set_cfg(32'h3);
    begin
      logic [DW-1:0] v;
      reg_read(4'd5, v);
      chk(v == 32'h0, "R9 deselected register pop", v, 32'h0);
    end
    expect_level("R9 level after deselected pop");
    hw_pop_check("R8 show-ahead word 2");
    hw_pop_check("R8 show-ahead word 3");
    hw_pop_check("R8 show-ahead word 4");
    hw_pop_check("R8 empty shows 0");
    expect_reg(4'd1, 32'h1, "R3 empty after hw drain");

    // R4/R5/R10: fill past capacity
    hw_burst(DEPTH + 2, 32'h1000_0000);
    expect_reg(4'd2, 32'h1, "R4 full");
    expect_reg(4'd1, 32'h0, "R3 not empty at full");
    expect_reg(4'd3, 32'h0, "R5 level wraps to 0");
    for (int i = 0; i < DEPTH; i++) hw_pop_check("R10 order after overflow drop");
    expect_reg(4'd1, 32'h1, "R10 empty after exact depth");
    expect_reg(4'd2, 32'h0, "R4 not full");

    // R11: clear command
    set_cfg(32'h0);
    sw_push(32'hC0DE_0001);
    sw_push(32'hC0DE_0002);
    sw_push(32'hC0DE_0003);
    reg_write(4'd6, 32'h2);
    expect_level("R11 clear without bit0 ignored");
    reg_write(4'd6, 32'h1);
    sb_q.delete();
    expect_reg(4'd1, 32'h1, "R11 empty after clear");
    expect_level("R11 level after clear");
    sw_pop_check("R11 pop after clear");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule